// File: doc/BRIEF.md
# GPU L2 Line Writeback-and-Bypass Controller

This block tracks one line of a write-back second-level GPU cache. It decides what happens to loads and atomics that reach that line. A clean hit is answered locally. A miss becomes a read request toward memory. An atomic is either performed in the L2 or sent onward. A request that finds the line dirty first causes a writeback. The request is then held in a small per-line stall queue until memory acknowledges the writeback, and the queue is replayed afterwards in arrival order.

A load that asks to bypass every cache level never allocates the line. If such a load finds the line dirty, the writeback and the read go out together. The line then sits in a separate waiting state that remembers the bypass. Because of that state, the writeback acknowledge is never taken for the read data, and only the later read response answers the load. Responses go through a delay line. A locally performed atomic spends extra cycles in it, so its response can overtake, or be overtaken by, other responses.

Top module: `wb_line_ctl`

## Requirements
- R1: After reset the line is absent and the stall queue is empty. `reqReady` is 1, and `rspValid`, `wbIssue`, `readMiss` and `atomicFwd` are 0.
- R2: A load (`reqIsAtomic`=0) to an absent line pulses `readMiss` in the cycle it is accepted. It is answered with its tag HIT_LAT cycles after the cycle in which `memRspValid` is seen. The line is then clean, and a later plain load is answered HIT_LAT cycles after acceptance with no `readMiss`.
- R3: An atomic (`reqIsAtomic`=1, `reqBypAll`=0) to a clean line is performed locally with no `atomicFwd`. It is answered HIT_LAT+ATOM_LAT cycles after acceptance, and the line becomes dirty.
- R4: An atomic is forwarded with `atomicFwd` when its `reqBypAll` is 1 or when the line is absent. `fwdBypAll` carries the request's bypass flag in the same cycle.
- R5: A forwarded atomic without the bypass flag to an absent line is performed when its read data returns. It is answered HIT_LAT+ATOM_LAT cycles after `memRspValid`, and the line becomes dirty.
- R6: A load without bypass to a dirty line pulses `wbIssue` in the cycle it is accepted and is taken off the input (`reqReady` 1). No response is produced for it until `wbAck` arrives.
- R7: An atomic to a dirty line pulses `wbIssue`. No `atomicFwd` and no response for it appear before `wbAck`. It is performed or forwarded in the first cycle after `wbAck`.
- R8: `wbAck` in the waiting state makes the line clean. The held requests are then replayed one per cycle in arrival order. A request that arrives during replay joins the queue behind them.
- R9: A bypass load (`reqIsAtomic`=0, `reqBypAll`=1) to a dirty line pulses `wbIssue` and `readMiss` in the same cycle. The following `wbAck` yields no response. The load is answered HIT_LAT cycles after the later `memRspValid`.
- R10: A bypass load never allocates the line. After it completes, a further load to the line pulses `readMiss` again.
- R11: Responses leave in order of their due cycle, not of request order. A bypass load issued one cycle after a local atomic can be answered before that atomic.
- R12: The stall queue holds STALL_DEPTH requests. With the queue full, `reqReady` is 0, and every held request is answered in order once the queue drains.
- R13: `wbAck` and `memRspValid` have no effect when the line is resting clean (no response, no writeback, no read, line stays clean).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqIsAtomic | input | 1 | 1 = atomic, 0 = load |
| reqBypAll | input | 1 | 1 = bypass all cache levels |
| reqTag | input | TAG_W | Requester tag returned with the response |
| wbAck | input | 1 | Writeback acknowledge from memory |
| memRspValid | input | 1 | Read or forwarded-atomic data returned from memory |
| wbIssue | output | 1 | Write the dirty line back |
| readMiss | output | 1 | Read request sent to memory |
| atomicFwd | output | 1 | Atomic passed on to memory |
| fwdBypAll | output | 1 | Bypass flag travelling with the forwarded atomic |
| rspValid | output | 1 | Response to a requester |
| rspTag | output | TAG_W | Tag of that response |

## Verification
The two functions that can fall in the same cycle are the replay of a held request at the head of the stall queue and the arrival of a new request, which must be appended behind the queue. The bench presents a fresh load in the first cycle after `wbAck`. It then checks that the replayed requests and the newcomer are answered in consecutive cycles in arrival order. A second coincidence, two responses due in the same delay slot, is avoided by the chosen timing, while a local atomic and a later bypass load are arranged so that their responses cross.

// File: rtl/wb_line_ctl_pkg.sv
package wb_line_ctl_pkg;
  typedef enum logic [2:0] {
    L_ABSENT,
    L_CLEAN,
    L_DIRTY,
    L_WAIT,
    L_WAIT_BYP,
    L_PEND
  } lineSt_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic rspIns;
    logic rspLong;
  } dpStrobe_t;
endpackage

// File: rtl/wb_line_fsm.sv
module wb_line_fsm
  import wb_line_ctl_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqIsAtomic,
  input  logic             reqBypAll,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             headIsAtomic,
  input  logic             headBypAll,
  input  logic [TAG_W-1:0] headTag,
  input  logic             empty,
  input  logic             full,
  input  logic             wbAck,
  input  logic             memRspValid,
  output logic             reqReady,
  output logic             wbIssue,
  output logic             readMiss,
  output logic             atomicFwd,
  output logic             fwdBypAll,
  output dpStrobe_t        stb,
  output logic [TAG_W-1:0] rspTagIn,
  output lineSt_e          lineState
);
  lineSt_e state, nxtState;
  logic pendAtom, pendNoAlloc, nxtPendAtom, nxtPendNoAlloc, pendLoad;
  logic [TAG_W-1:0] pendTag;
  logic stable, useHead, curAtom, curByp, curValid, bypLoad, parkCur, consume;
  logic [TAG_W-1:0] curTag;

  assign lineState = state;

  always_comb begin
    stable   = (state == L_ABSENT) || (state == L_CLEAN) || (state == L_DIRTY);
    useHead  = !empty;
    curAtom  = useHead ? headIsAtomic : reqIsAtomic;
    curByp   = useHead ? headBypAll : reqBypAll;
    curTag   = useHead ? headTag : reqTag;
    curValid = stable && (useHead || reqValid);
    bypLoad  = !curAtom && curByp;
    parkCur  = (state == L_DIRTY) && !bypLoad;
    consume  = curValid && !parkCur;
    reqReady = !full;

    nxtState       = state;
    nxtPendAtom    = pendAtom;
    nxtPendNoAlloc = pendNoAlloc;
    pendLoad       = 1'b0;
    wbIssue        = 1'b0;
    readMiss       = 1'b0;
    atomicFwd      = 1'b0;
    fwdBypAll      = 1'b0;
    rspTagIn       = curTag;
    stb.rspIns     = 1'b0;
    stb.rspLong    = 1'b0;
    stb.pop        = useHead && consume;
    stb.push       = reqValid && !full && !(stable && !useHead && consume);

    if (curValid) begin
      unique case (state)
        L_ABSENT: begin
          pendLoad       = 1'b1;
          nxtPendAtom    = curAtom;
          nxtPendNoAlloc = curByp;
          nxtState       = L_PEND;
          if (curAtom) begin
            atomicFwd = 1'b1;
            fwdBypAll = curByp;
          end else begin
            readMiss = 1'b1;
          end
        end
        L_CLEAN: begin
          if (!curByp) begin
            stb.rspIns  = 1'b1;
            stb.rspLong = curAtom;
            if (curAtom) nxtState = L_DIRTY;
          end else begin
            pendLoad       = 1'b1;
            nxtPendAtom    = curAtom;
            nxtPendNoAlloc = 1'b1;
            nxtState       = L_PEND;
            atomicFwd      = curAtom;
            fwdBypAll      = curAtom;
            readMiss       = !curAtom;
          end
        end
        L_DIRTY: begin
          wbIssue = 1'b1;
          if (bypLoad) begin
            readMiss       = 1'b1;
            pendLoad       = 1'b1;
            nxtPendAtom    = 1'b0;
            nxtPendNoAlloc = 1'b1;
            nxtState       = L_WAIT_BYP;
          end else begin
            nxtState = L_WAIT;
          end
        end
        default: ;
      endcase
    end

    if (state == L_PEND && memRspValid) begin
      stb.rspIns  = 1'b1;
      stb.rspLong = pendAtom && !pendNoAlloc;
      rspTagIn    = pendTag;
      nxtState    = pendNoAlloc ? L_ABSENT : (pendAtom ? L_DIRTY : L_CLEAN);
    end
    if (state == L_WAIT && wbAck) nxtState = L_CLEAN;
    if (state == L_WAIT_BYP && wbAck) nxtState = L_PEND;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= L_ABSENT;
      pendAtom    <= 1'b0;
      pendNoAlloc <= 1'b0;
      pendTag     <= '0;
    end else begin
      state       <= nxtState;
      pendAtom    <= nxtPendAtom;
      pendNoAlloc <= nxtPendNoAlloc;
      if (pendLoad) pendTag <= curTag;
    end
  end
endmodule

// File: rtl/wb_line_dp.sv
module wb_line_dp
  import wb_line_ctl_pkg::*;
#(
  parameter int TAG_W       = 4,
  parameter int STALL_DEPTH = 4,
  parameter int HIT_LAT     = 2,
  parameter int ATOM_LAT    = 4,
  localparam int CNT_W      = $clog2(STALL_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic             inIsAtomic,
  input  logic             inBypAll,
  input  logic [TAG_W-1:0] inTag,
  input  logic [TAG_W-1:0] rspTagIn,
  output logic             headIsAtomic,
  output logic             headBypAll,
  output logic [TAG_W-1:0] headTag,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] stallCount,
  output logic             rspValid,
  output logic [TAG_W-1:0] rspTag
);
  localparam int PTR_W     = (STALL_DEPTH > 1) ? $clog2(STALL_DEPTH) : 1;
  localparam int DLY_D     = HIT_LAT + ATOM_LAT;
  localparam int SHORT_IDX = HIT_LAT - 1;
  localparam int LONG_IDX  = DLY_D - 1;

  // stall queue
  logic             qAtom [STALL_DEPTH];
  logic             qByp  [STALL_DEPTH];
  logic [TAG_W-1:0] qTag  [STALL_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  assign empty        = (stallCount == '0);
  assign full         = (stallCount == CNT_W'(STALL_DEPTH));
  assign headIsAtomic = qAtom[rdPtr];
  assign headBypAll   = qByp[rdPtr];
  assign headTag      = qTag[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      stallCount <= '0;
    end else begin
      if (stb.push) wrPtr <= (wrPtr == PTR_W'(STALL_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (stb.pop)  rdPtr <= (rdPtr == PTR_W'(STALL_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({stb.push, stb.pop})
        2'b10:   stallCount <= stallCount + 1'b1;
        2'b01:   stallCount <= stallCount - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push) begin
      qAtom[wrPtr] <= inIsAtomic;
      qByp[wrPtr]  <= inBypAll;
      qTag[wrPtr]  <= inTag;
    end
  end

  // response delay line: slot 0 drives the output
  logic             slotV [DLY_D];
  logic [TAG_W-1:0] slotT [DLY_D];
  logic             shV   [DLY_D];
  logic [TAG_W-1:0] shT   [DLY_D];
  logic             nxtV  [DLY_D];
  logic [TAG_W-1:0] nxtT  [DLY_D];

  for (genvar g = 0; g < DLY_D; g++) begin : gShift
    if (g < DLY_D - 1) begin : gMid
      assign shV[g] = slotV[g+1];
      assign shT[g] = slotT[g+1];
    end else begin : gEnd
      assign shV[g] = 1'b0;
      assign shT[g] = '0;
    end
  end

  always_comb begin
    logic placed;
    int   baseIdx;
    placed  = 1'b0;
    baseIdx = stb.rspLong ? LONG_IDX : SHORT_IDX;
    for (int i = 0; i < DLY_D; i++) begin
      nxtV[i] = shV[i];
      nxtT[i] = shT[i];
    end
    for (int i = 0; i < DLY_D; i++) begin
      if (stb.rspIns && !placed && i >= baseIdx && !shV[i]) begin
        nxtV[i] = 1'b1;
        nxtT[i] = rspTagIn;
        placed  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DLY_D; i++) begin
      if (!rstN) begin
        slotV[i] <= 1'b0;
        slotT[i] <= '0;
      end else begin
        slotV[i] <= nxtV[i];
        slotT[i] <= nxtT[i];
      end
    end
  end

  assign rspValid = slotV[0];
  assign rspTag   = slotT[0];
endmodule

// File: rtl/wb_line_ctl.sv
module wb_line_ctl
  import wb_line_ctl_pkg::*;
#(
  parameter int TAG_W       = 4,
  parameter int STALL_DEPTH = 4,
  parameter int HIT_LAT     = 2,
  parameter int ATOM_LAT    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqIsAtomic,
  input  logic             reqBypAll,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             wbAck,
  input  logic             memRspValid,
  output logic             wbIssue,
  output logic             readMiss,
  output logic             atomicFwd,
  output logic             fwdBypAll,
  output logic             rspValid,
  output logic [TAG_W-1:0] rspTag
);
  localparam int CNT_W = $clog2(STALL_DEPTH + 1);

  dpStrobe_t        stb;
  lineSt_e          lineState;
  logic             headIsAtomic, headBypAll, empty, full;
  logic [TAG_W-1:0] headTag, rspTagIn;
  logic [CNT_W-1:0] stallCount;

  wb_line_fsm #(.TAG_W(TAG_W)) uFsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsAtomic(reqIsAtomic),
    .reqBypAll(reqBypAll), .reqTag(reqTag), .headIsAtomic(headIsAtomic),
    .headBypAll(headBypAll), .headTag(headTag), .empty(empty), .full(full),
    .wbAck(wbAck), .memRspValid(memRspValid), .reqReady(reqReady),
    .wbIssue(wbIssue), .readMiss(readMiss), .atomicFwd(atomicFwd),
    .fwdBypAll(fwdBypAll), .stb(stb), .rspTagIn(rspTagIn), .lineState(lineState)
  );

  wb_line_dp #(
    .TAG_W(TAG_W), .STALL_DEPTH(STALL_DEPTH), .HIT_LAT(HIT_LAT), .ATOM_LAT(ATOM_LAT)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .inIsAtomic(reqIsAtomic),
    .inBypAll(reqBypAll), .inTag(reqTag), .rspTagIn(rspTagIn),
    .headIsAtomic(headIsAtomic), .headBypAll(headBypAll), .headTag(headTag),
    .empty(empty), .full(full), .stallCount(stallCount),
    .rspValid(rspValid), .rspTag(rspTag)
  );
endmodule

// File: rtl/wb_line_ctl_chk.sv
module wb_line_ctl_chk
  import wb_line_ctl_pkg::*;
#(
  parameter int STALL_DEPTH = 4,
  localparam int CNT_W      = $clog2(STALL_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input lineSt_e          lineState,
  input logic             reqReady,
  input logic             wbIssue,
  input logic             readMiss,
  input logic             atomicFwd,
  input logic             wbAck,
  input logic [CNT_W-1:0] stallCount
);
  AST_WB_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    wbIssue |=> (lineState == L_WAIT || lineState == L_WAIT_BYP)); // R6

  AST_WAIT_HOLDS_ATOMIC: assert property (@(posedge clk) disable iff (!rstN)
    (lineState == L_WAIT || lineState == L_WAIT_BYP) |-> (!atomicFwd && !wbIssue)); // R7

  AST_BYP_EVICT_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (wbIssue && readMiss) |=> lineState == L_WAIT_BYP); // R9

  AST_ACK_NOT_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (lineState == L_WAIT_BYP && wbAck) |=> lineState == L_PEND); // R9

  AST_FWD_FROM_REST: assert property (@(posedge clk) disable iff (!rstN)
    atomicFwd |-> (lineState == L_ABSENT || lineState == L_CLEAN)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (stallCount == CNT_W'(STALL_DEPTH)) |-> !reqReady); // R12

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stallCount <= CNT_W'(STALL_DEPTH)); // R12
endmodule

bind wb_line_ctl wb_line_ctl_chk #(.STALL_DEPTH(STALL_DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .lineState(lineState), .reqReady(reqReady),
  .wbIssue(wbIssue), .readMiss(readMiss), .atomicFwd(atomicFwd),
  .wbAck(wbAck), .stallCount(stallCount)
);

// File: tb/wb_line_ctl_test.sv
`timescale 1ns/1ps
module wb_line_ctl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqIsAtomic = 1'b0, reqBypAll = 1'b0;
  logic [3:0] reqTag = '0;
  logic wbAck = 1'b0, memRspValid = 1'b0;
  logic reqReady, wbIssue, readMiss, atomicFwd, fwdBypAll, rspValid;
  logic [3:0] rspTag;

  wb_line_ctl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsAtomic(reqIsAtomic), .reqBypAll(reqBypAll), .reqTag(reqTag),
    .wbAck(wbAck), .memRspValid(memRspValid), .wbIssue(wbIssue),
    .readMiss(readMiss), .atomicFwd(atomicFwd), .fwdBypAll(fwdBypAll),
    .rspValid(rspValid), .rspTag(rspTag)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  int checks = 0, failures = 0;
  int rspTagLog [64];
  int rspCycLog [64];
  int rspN = 0, mark = 0;
  int wbCnt = 0, wbCyc = -1, missCnt = 0, missCyc = -1, fwdCnt = 0, fwdCyc = -1;
  bit fwdByp = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (rspValid && rspN < 64) begin
        rspTagLog[rspN] = int'(rspTag);
        rspCycLog[rspN] = cyc;
        rspN++;
      end
      if (wbIssue)   begin wbCnt++;   wbCyc = cyc;   end
      if (readMiss)  begin missCnt++; missCyc = cyc; end
      if (atomicFwd) begin fwdCnt++;  fwdCyc = cyc; fwdByp = fwdBypAll; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int findRsp(input int tag);
    for (int i = mark; i < rspN; i++) if (rspTagLog[i] == tag) return i;
    return -1;
  endfunction

  function automatic int rspCyc(input int tag);
    int idx;
    idx = findRsp(tag);
    return (idx < 0) ? -1 : rspCycLog[idx];
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic issue(input bit atom, input bit byp, input int tag, output int at);
    reqValid = 1'b1; reqIsAtomic = atom; reqBypAll = byp; reqTag = 4'(tag);
    forever begin
      @(negedge clk);
      if (reqReady) break;
      @(posedge clk); #1;
    end
    at = cyc;
    step();
    reqValid = 1'b0; reqIsAtomic = 1'b0; reqBypAll = 1'b0;
  endtask

  task automatic ack(output int at);
    wbAck = 1'b1; at = cyc; step(); wbAck = 1'b0;
  endtask

  task automatic memRsp(output int at);
    memRspValid = 1'b1; at = cyc; step(); memRspValid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    chk(rspValid == 1'b0, "R1", "rspValid after reset", int'(rspValid), 0);
    chk(!wbIssue && !readMiss && !atomicFwd, "R1", "strobes after reset",
        int'({wbIssue, readMiss, atomicFwd}), 0);
    step();
  endtask

  task automatic t_miss_then_hit();
    int c, m, c2, miss0;
    mark = rspN;
    issue(0, 0, 1, c);
    chk(missCyc == c, "R2", "readMiss cycle", missCyc, c);
    idle(3);
    chk(findRsp(1) < 0, "R2", "no response before data", findRsp(1), -1);
    memRsp(m); idle(4);
    chk(rspCyc(1) == m + 2, "R2", "miss response cycle", rspCyc(1), m + 2);
    miss0 = missCnt;
    issue(0, 0, 2, c2); idle(4);
    chk(missCnt == miss0, "R2", "hit without readMiss", missCnt, miss0);
    chk(rspCyc(2) == c2 + 2, "R2", "hit response cycle", rspCyc(2), c2 + 2);
  endtask

  task automatic t_local_atomic();
    int c, f0;
    mark = rspN; f0 = fwdCnt;
    issue(1, 0, 3, c); idle(8);
    chk(fwdCnt == f0, "R3", "local atomic not forwarded", fwdCnt, f0);
    chk(rspCyc(3) == c + 6, "R3", "local atomic response cycle", rspCyc(3), c + 6);
  endtask

  task automatic t_dirty_load_replay();
    int c, c5, a, c6, w0;
    mark = rspN; w0 = wbCnt;
    issue(0, 0, 4, c);
    chk(wbCyc == c, "R6", "writeback on dirty load", wbCyc, c);
    issue(0, 0, 5, c5);
    idle(3);
    chk(findRsp(4) < 0, "R6", "no response before ack", findRsp(4), -1);
    ack(a);
    issue(0, 0, 6, c6);   // same cycle as first replay
    idle(6);
    chk(rspCyc(4) == a + 3, "R8", "first replay response", rspCyc(4), a + 3);
    chk(rspCyc(5) == a + 4, "R8", "second replay response", rspCyc(5), a + 4);
    chk(rspCyc(6) == a + 5, "R8", "newcomer behind replay", rspCyc(6), a + 5);
    chk(wbCnt == w0 + 1, "R6", "single writeback", wbCnt, w0 + 1);
  endtask

  task automatic t_dirty_atomic();
    int c, c8, a, c9, a2, m, f0;
    mark = rspN;
    issue(1, 0, 7, c); idle(7);
    f0 = fwdCnt;
    issue(1, 0, 8, c8);
    chk(wbCyc == c8, "R7", "writeback on dirty atomic", wbCyc, c8);
    idle(3);
    chk(findRsp(8) < 0 && fwdCnt == f0, "R7", "atomic held before ack", findRsp(8), -1);
    ack(a); idle(9);
    chk(rspCyc(8) == a + 7, "R7", "atomic performed after ack", rspCyc(8), a + 7);
    chk(fwdCnt == f0, "R7", "replayed atomic stays local", fwdCnt, f0);
    issue(1, 1, 9, c9);
    chk(wbCyc == c9, "R7", "writeback before bypass atomic", wbCyc, c9);
    idle(2);
    chk(fwdCnt == f0, "R7", "bypass atomic not forwarded before ack", fwdCnt, f0);
    ack(a2); idle(2);
    chk(fwdCyc == a2 + 1, "R7", "bypass atomic forwarded after ack", fwdCyc, a2 + 1);
    chk(fwdByp == 1'b1, "R4", "bypass flag forwarded", int'(fwdByp), 1);
    memRsp(m); idle(4);
    chk(rspCyc(9) == m + 2, "R4", "forwarded atomic response", rspCyc(9), m + 2);
  endtask

  task automatic t_absent_atomic();
    int c, m, c2, w0;
    mark = rspN;
    issue(1, 0, 10, c);
    chk(fwdCyc == c && fwdByp == 1'b0, "R4", "absent-line atomic forwarded", fwdCyc, c);
    memRsp(m); idle(8);
    chk(rspCyc(10) == m + 6, "R5", "atomic done on return path", rspCyc(10), m + 6);
    w0 = wbCnt;
    issue(0, 1, 11, c2);
    chk(wbCnt == w0 + 1, "R5", "line left dirty", wbCnt, w0 + 1);
  endtask

  task automatic t_bypass_evict();
    int c, a, m, c12, m2;
    mark = rspN;
    c = wbCyc;
    chk(missCyc == c, "R9", "writeback and read together", missCyc, c);
    ack(a); idle(4);
    chk(findRsp(11) < 0, "R9", "ack is not read data", findRsp(11), -1);
    memRsp(m); idle(4);
    chk(rspCyc(11) == m + 2, "R9", "bypass read answered", rspCyc(11), m + 2);
    issue(0, 0, 12, c12);
    chk(missCyc == c12, "R10", "line not allocated after bypass evict", missCyc, c12);
    memRsp(m2); idle(4);
  endtask

  task automatic t_bypass_clean();
    int c, m, c14, m2;
    mark = rspN;
    issue(0, 1, 13, c);
    chk(missCyc == c, "R10", "bypass load on clean line reads", missCyc, c);
    memRsp(m); idle(4);
    chk(rspCyc(13) == m + 2, "R10", "bypass load response", rspCyc(13), m + 2);
    issue(0, 0, 14, c14);
    chk(missCyc == c14, "R10", "no allocation by bypass load", missCyc, c14);
    memRsp(m2); idle(4);
  endtask

  task automatic t_out_of_order();
    int c, c2, a, m;
    mark = rspN;
    issue(1, 0, 1, c);
    issue(0, 1, 2, c2);
    ack(a);
    memRsp(m);
    idle(6);
    chk(rspCyc(2) == c + 5, "R11", "bypass load response", rspCyc(2), c + 5);
    chk(rspCyc(1) == c + 6, "R11", "local atomic response", rspCyc(1), c + 6);
    chk(findRsp(2) < findRsp(1), "R11", "later request answered first",
        findRsp(2), findRsp(1) - 1);
  endtask

  task automatic t_full_queue();
    int c, m, a;
    bit ok;
    issue(0, 0, 0, c); memRsp(m); idle(3);
    issue(1, 0, 15, c); idle(7);
    mark = rspN;
    for (int t = 0; t < 4; t++) issue(0, 0, t, c);
    reqValid = 1'b1; reqIsAtomic = 1'b0; reqBypAll = 1'b0; reqTag = 4'd4;
    @(negedge clk);
    chk(reqReady == 1'b0, "R12", "ready low when queue full", int'(reqReady), 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(reqReady == 1'b0, "R12", "ready stays low", int'(reqReady), 0);
    @(posedge clk); #1;
    wbAck = 1'b1; a = cyc;
    step(); wbAck = 1'b0;
    forever begin
      @(negedge clk);
      if (reqReady) break;
      @(posedge clk); #1;
    end
    step();
    reqValid = 1'b0;
    idle(10);
    ok = 1'b1;
    for (int t = 0; t < 5; t++) begin
      if (findRsp(t) < 0) ok = 1'b0;
      if (t > 0 && findRsp(t) <= findRsp(t - 1)) ok = 1'b0;
    end
    chk(ok, "R12", "all held requests answered in order", rspN - mark, 5);
    chk(rspCyc(0) == a + 3, "R12", "drain starts after ack", rspCyc(0), a + 3);
  endtask

  task automatic t_ignored();
    int a, m, c, w0, m0;
    mark = rspN; w0 = wbCnt; m0 = missCnt;
    ack(a); memRsp(m); idle(4);
    chk(rspN == mark, "R13", "stray ack/data no response", rspN - mark, 0);
    chk(wbCnt == w0 && missCnt == m0, "R13", "stray ack/data no traffic",
        wbCnt + missCnt, w0 + m0);
    issue(0, 0, 9, c); idle(4);
    chk(missCnt == m0 && rspCyc(9) == c + 2, "R13", "line still clean", rspCyc(9), c + 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_miss_then_hit();
    t_local_atomic();
    t_dirty_load_replay();
    t_dirty_atomic();
    t_absent_atomic();
    t_bypass_evict();
    t_bypass_clean();
    t_out_of_order();
    t_full_queue();
    t_ignored();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule